// File: doc/BRIEF.md
# SD Command Line Sequencer

This block owns the one-wire command signal of an SD/MMC card port. A host presents a command index, a 32-bit argument and the kind of reply it expects. The block then optionally warms the card up with a run of idle-high clocks, shifts out a 48-bit command frame with its CRC7, and hunts for the card's reply within a bounded turnaround window. It collects the reply (48 or 136 bits), checks the CRC7 of a short reply, and enforces a fixed idle gap before it takes the next request.

All timing is counted in card-clock enable pulses (`clk_en`). The line is sampled on those pulses and driven on them. A 4-bit state code exposes the frame field being handled at any moment, so that debug logic or a status register can read it. The field index of the most recent reply is held until the next reply arrives. Stop commands that a data engine issues on its own pass through this same path, so their replies update it too.

Top module: `sd_cmd_path`

## Requirements
- R1: After synchronous reset, `state_code` is 0, `req_ready` is 1, `cmd_oe`, `done` and all error flags are 0, and `last_index` is 0.
- R2: The first accepted request after reset enters code 1 for exactly INIT_CLKS (80) enable pulses, with `cmd_oe`=1 and `cmd_o`=1, before the start bit. Later requests go straight to code 2.
- R3: The command frame is 48 bits, sent MSB first with one bit per enable pulse: 0, 1, index[5:0], argument[31:0], CRC7[6:0], 1. `cmd_oe` stays 1 through the whole frame and drops on the pulse that ends the end bit.
- R4: The CRC7 uses x^7+x^3+1, starts from zero, and covers the first 40 frame bits. For index 0 with argument 0 it is 0x4A; for index 8 with argument 0x1AA it is 0x43.
- R5: While bit b of the command is on the line, `state_code` is 2 for b=0, 3 for b=1, 4 for b=2..39, 5 for b=40..46 and 6 for b=47.
- R6: With `req_rsp`=00 (no reply), `done` pulses for one clock when the end bit completes. The block then shows code 14 for exactly NCC_CLKS (8) enable pulses and returns to code 0.
- R7: With a reply expected (`req_rsp`=01 short, 1x long), the block shows code 15 and waits up to TURN_MAX (64) enable pulses for a sampled 0. If none comes, it sets `err_timeout`, pulses `done` and enters code 14.
- R8: A short reply is 48 bits: start, direction bit, index[5:0], 32-bit payload, CRC7, end bit. After sampling reply bit j, the code is 7 (j=0), 9 (j=1), 10 (j=2..7), 11 (payload), 12 (CRC) or 13 (end). The payload appears on `rsp_payload[31:0]` with the upper bits 0. `err_crc` is set when the received CRC differs from one recomputed over the first 40 reply bits.
- R9: A long reply is 136 bits: start, direction bit, 6-bit index field, 120-bit payload on `rsp_payload`, 7 trailing bits that are not checked (`err_crc` stays 0), and an end bit.
- R10: A sampled end bit of 0 sets `err_end`. `done` pulses on entry to code 13, and one enable pulse later the block enters code 14.
- R11: `last_index` takes the index field of every reply received, whatever command caused it. It does not change on a timeout or on a command without a reply.
- R12: A request presented while the block is not idle has no effect: the frame in flight and the reply handling are unchanged, and `req_ready` is 1 only at code 0.
- R13: Outside code 0, the state code changes only on clocks where `clk_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Card-clock enable pulse |
| req_valid | input | 1 | Command request, taken when idle |
| req_index | input | 6 | Command index |
| req_arg | input | 32 | Command argument |
| req_rsp | input | 2 | Reply kind: 00 none, 01 short, 1x long |
| req_ready | output | 1 | Block is idle and can take a request |
| cmd_o | output | 1 | Command line drive value |
| cmd_oe | output | 1 | Command line drive enable |
| cmd_i | input | 1 | Command line sampled value |
| done | output | 1 | One-clock pulse when a command or reply completes |
| err_timeout | output | 1 | No start bit within the turnaround window |
| err_crc | output | 1 | Short-reply CRC7 mismatch |
| err_end | output | 1 | Reply end bit was 0 |
| rsp_payload | output | 120 | Reply payload |
| last_index | output | 6 | Index field of the most recent reply |
| state_code | output | 4 | Current phase code |

## Verification
A wrong bit count or a field boundary off by one shows within one enable pulse on `state_code`, because every field owns its own code. It also shows at the end of the command as a mismatched captured frame, or as a reply that is cut short or overruns into code 13. A stuck or mis-seeded CRC register shows as a wrong CRC field on the line for known commands, or as `err_crc` raised on a clean reply. Counter faults in the warm-up, turnaround or gap phases change the number of enable pulses spent in codes 1, 15 or 14, and the bench counts those pulses exactly.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;

  typedef enum logic [3:0] {
    ST_IDLE     = 4'd0,
    ST_INIT     = 4'd1,
    ST_TX_START = 4'd2,
    ST_TX_DIR   = 4'd3,
    ST_TX_BODY  = 4'd4,
    ST_TX_CRC   = 4'd5,
    ST_TX_END   = 4'd6,
    ST_RX_START = 4'd7,
    ST_RX_IRQ   = 4'd8,
    ST_RX_DIR   = 4'd9,
    ST_RX_IDX   = 4'd10,
    ST_RX_BODY  = 4'd11,
    ST_RX_CRC   = 4'd12,
    ST_RX_END   = 4'd13,
    ST_GAP      = 4'd14,
    ST_TURN     = 4'd15
  } cmd_state_e;

  localparam int FRAME_BITS = 48;
  localparam int LONG_BITS  = 136;
  localparam int CRC_SPAN   = 40;
  localparam int LONG_BODY  = 120;
  localparam int SHORT_BODY = 32;

  // Serial CRC7 (x^7 + x^3 + 1), zero seed, MSB first.
  function automatic logic [6:0] crc7_calc(input logic [CRC_SPAN-1:0] d);
    logic [6:0] c;
    logic       fb;
    c = '0;
    for (int i = CRC_SPAN - 1; i >= 0; i--) begin
      fb = d[i] ^ c[6];
      c  = {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
    end
    return c;
  endfunction

  // Code for command bit b on the line.
  function automatic cmd_state_e tx_code(input logic [7:0] b);
    if (b == 8'd0)       return ST_TX_START;
    else if (b == 8'd1)  return ST_TX_DIR;
    else if (b < 8'd40)  return ST_TX_BODY;
    else if (b < 8'd47)  return ST_TX_CRC;
    else                 return ST_TX_END;
  endfunction

  // Code after n reply bits have been sampled.
  function automatic cmd_state_e rx_code(input logic [7:0] n, input logic lng);
    logic [7:0] total;
    total = lng ? 8'(LONG_BITS) : 8'(FRAME_BITS);
    if (n == 8'd1)                return ST_RX_START;
    else if (n == 8'd2)           return ST_RX_DIR;
    else if (n <= 8'd8)           return ST_RX_IDX;
    else if (n <= total - 8'd8)   return ST_RX_BODY;
    else if (n <= total - 8'd1)   return ST_RX_CRC;
    else                          return ST_RX_END;
  endfunction

endpackage

// File: rtl/sd_crc7_ser.sv
module sd_crc7_ser (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       en,
  input  logic       din,
  output logic [6:0] crc
);
  logic fb;
  assign fb = din ^ crc[6];

  always_ff @(posedge clk) begin
    if (rst || clr) crc <= '0;
    else if (en)    crc <= {crc[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
  end
endmodule

// File: rtl/sd_cmd_tick.sv
module sd_cmd_tick #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);
  logic [W-1:0] cnt;
  assign zero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (dec && !zero) cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/sd_cmd_path.sv
module sd_cmd_path
  import sd_cmd_pkg::*;
#(
  parameter int INIT_CLKS = 80,
  parameter int NCC_CLKS  = 8,
  parameter int TURN_MAX  = 64
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clk_en,
  input  logic           req_valid,
  input  logic [5:0]     req_index,
  input  logic [31:0]    req_arg,
  input  logic [1:0]     req_rsp,
  output logic           req_ready,
  output logic           cmd_o,
  output logic           cmd_oe,
  input  logic           cmd_i,
  output logic           done,
  output logic           err_timeout,
  output logic           err_crc,
  output logic           err_end,
  output logic [119:0]   rsp_payload,
  output logic [5:0]     last_index,
  output logic [3:0]     state_code
);
  localparam int MAX_A   = (INIT_CLKS > TURN_MAX) ? INIT_CLKS : TURN_MAX;
  localparam int CNT_MAX = (MAX_A > NCC_CLKS) ? MAX_A : NCC_CLKS;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  cmd_state_e            st;
  logic                  init_done;
  logic [FRAME_BITS-1:0] txsr;
  logic [7:0]            nbit;
  logic [LONG_BITS-1:0]  rsr;
  logic [LONG_BITS-1:0]  rsr_nx;
  logic                  rsp_long, rsp_none;
  logic                  accept;
  logic [FRAME_BITS-1:0] frame;
  logic [CRC_SPAN-1:0]   head;
  logic [7:0]            rx_total;
  logic [7:0]            nbit_inc;

  logic             tick_load, tick_dec, tick_zero;
  logic [CNT_W-1:0] tick_val;
  logic             crc_clr, crc_en;
  logic [6:0]       crc_q;

  assign accept     = req_valid && (st == ST_IDLE);
  assign req_ready  = (st == ST_IDLE);
  assign state_code = st;
  assign head       = {1'b0, 1'b1, req_index, req_arg};
  assign frame      = {head, crc7_calc(head), 1'b1};
  assign rsr_nx     = {rsr[LONG_BITS-2:0], cmd_i};
  assign rx_total   = rsp_long ? 8'(LONG_BITS) : 8'(FRAME_BITS);
  assign nbit_inc   = nbit + 8'd1;

  sd_cmd_tick #(.W(CNT_W)) u_tick (
    .clk(clk), .rst(rst), .load(tick_load), .load_val(tick_val),
    .dec(tick_dec), .zero(tick_zero)
  );

  sd_crc7_ser u_rx_crc (
    .clk(clk), .rst(rst), .clr(crc_clr), .en(crc_en), .din(cmd_i), .crc(crc_q)
  );

  // Phase counter and receive CRC control.
  always_comb begin
    tick_load = 1'b0;
    tick_dec  = 1'b0;
    tick_val  = '0;
    crc_clr   = 1'b0;
    crc_en    = 1'b0;
    if (accept) begin
      tick_load = !init_done;
      tick_val  = CNT_W'(INIT_CLKS - 1);
    end else if (clk_en) begin
      unique case (st)
        ST_INIT: tick_dec = 1'b1;
        ST_TX_END: begin
          tick_load = 1'b1;
          tick_val  = rsp_none ? CNT_W'(NCC_CLKS - 1) : CNT_W'(TURN_MAX - 1);
          crc_clr   = 1'b1;
        end
        ST_TURN: begin
          if (cmd_i && tick_zero) begin
            tick_load = 1'b1;
            tick_val  = CNT_W'(NCC_CLKS - 1);
          end else if (cmd_i) begin
            tick_dec = 1'b1;
          end
        end
        ST_RX_START, ST_RX_DIR, ST_RX_IDX, ST_RX_BODY, ST_RX_CRC:
          crc_en = (nbit < 8'(CRC_SPAN));
        ST_RX_END: begin
          tick_load = 1'b1;
          tick_val  = CNT_W'(NCC_CLKS - 1);
        end
        ST_GAP: tick_dec = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      init_done   <= 1'b0;
      cmd_o       <= 1'b1;
      cmd_oe      <= 1'b0;
      txsr        <= '0;
      nbit        <= '0;
      rsr         <= '0;
      rsp_long    <= 1'b0;
      rsp_none    <= 1'b1;
      done        <= 1'b0;
      err_timeout <= 1'b0;
      err_crc     <= 1'b0;
      err_end     <= 1'b0;
      rsp_payload <= '0;
      last_index  <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        txsr        <= frame;
        rsp_none    <= (req_rsp == 2'b00);
        rsp_long    <= req_rsp[1];
        err_timeout <= 1'b0;
        err_crc     <= 1'b0;
        err_end     <= 1'b0;
        cmd_oe      <= 1'b1;
        nbit        <= '0;
        if (init_done) begin
          st    <= ST_TX_START;
          cmd_o <= frame[FRAME_BITS-1];
        end else begin
          st    <= ST_INIT;
          cmd_o <= 1'b1;
        end
      end else if (clk_en) begin
        unique case (st)
          ST_INIT: if (tick_zero) begin
            st        <= ST_TX_START;
            init_done <= 1'b1;
            cmd_o     <= txsr[FRAME_BITS-1];
          end
          ST_TX_START, ST_TX_DIR, ST_TX_BODY, ST_TX_CRC: begin
            txsr  <= txsr << 1;
            cmd_o <= txsr[FRAME_BITS-2];
            nbit  <= nbit_inc;
            st    <= tx_code(nbit_inc);
          end
          ST_TX_END: begin
            cmd_oe <= 1'b0;
            cmd_o  <= 1'b1;
            if (rsp_none) begin
              st   <= ST_GAP;
              done <= 1'b1;
            end else begin
              st <= ST_TURN;
            end
          end
          ST_TURN: begin
            if (!cmd_i) begin
              st   <= ST_RX_START;
              nbit <= 8'd1;
              rsr  <= rsr_nx;
            end else if (tick_zero) begin
              st          <= ST_GAP;
              done        <= 1'b1;
              err_timeout <= 1'b1;
            end
          end
          ST_RX_START, ST_RX_DIR, ST_RX_IDX, ST_RX_BODY, ST_RX_CRC: begin
            rsr  <= rsr_nx;
            nbit <= nbit_inc;
            st   <= rx_code(nbit_inc, rsp_long);
            if (nbit_inc == rx_total) begin
              done    <= 1'b1;
              err_end <= !cmd_i;
              if (rsp_long) begin
                last_index  <= rsr_nx[133:128];
                rsp_payload <= rsr_nx[127:8];
                err_crc     <= 1'b0;
              end else begin
                last_index  <= rsr_nx[45:40];
                rsp_payload <= {{(LONG_BODY-SHORT_BODY){1'b0}}, rsr_nx[39:8]};
                err_crc     <= (crc_q != rsr_nx[7:1]);
              end
            end
          end
          ST_RX_END: st <= ST_GAP;
          ST_GAP:    if (tick_zero) st <= ST_IDLE;
          ST_IDLE:   ;
          default:   st <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/sd_cmd_path_chk.sv
module sd_cmd_path_chk (
  input logic       clk,
  input logic       rst,
  input logic       clk_en,
  input logic       req_valid,
  input logic       cmd_o,
  input logic       cmd_oe,
  input logic       done,
  input logic       err_timeout,
  input logic [3:0] state_code
);

  assert_oe_tx_only_R3: assert property (@(posedge clk) disable iff (rst)
    cmd_oe |-> (state_code >= 4'd1 && state_code <= 4'd6));

  assert_init_high_R2: assert property (@(posedge clk) disable iff (rst)
    (state_code == 4'd1) |-> (cmd_oe && cmd_o));

  assert_start_low_R5: assert property (@(posedge clk) disable iff (rst)
    (state_code == 4'd2) |-> (cmd_oe && !cmd_o));

  assert_dir_high_R5: assert property (@(posedge clk) disable iff (rst)
    (state_code == 4'd3) |-> cmd_o);

  assert_end_high_R3: assert property (@(posedge clk) disable iff (rst)
    (state_code == 4'd6) |-> (cmd_oe && cmd_o));

  assert_hold_R13: assert property (@(posedge clk) disable iff (rst)
    (!clk_en && state_code != 4'd0) |=> $stable(state_code));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_gap_exit_R6: assert property (@(posedge clk) disable iff (rst)
    (state_code == 4'd14) |=> (state_code == 4'd14 || state_code == 4'd0));

  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (state_code == 4'd0 && !req_valid) |=> (state_code == 4'd0));

  assert_timeout_gap_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(err_timeout) |-> (done && state_code == 4'd14));

endmodule

bind sd_cmd_path sd_cmd_path_chk u_chk (
  .clk(clk), .rst(rst), .clk_en(clk_en), .req_valid(req_valid),
  .cmd_o(cmd_o), .cmd_oe(cmd_oe), .done(done), .err_timeout(err_timeout),
  .state_code(state_code)
);

// File: tb/tb_sd_cmd_path.sv
module tb_sd_cmd_path;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         clk_en = 1'b0;
  logic         req_valid = 1'b0;
  logic [5:0]   req_index = '0;
  logic [31:0]  req_arg = '0;
  logic [1:0]   req_rsp = '0;
  logic         cmd_i = 1'b1;
  logic         req_ready, cmd_o, cmd_oe, done, err_timeout, err_crc, err_end;
  logic [119:0] rsp_payload;
  logic [5:0]   last_index;
  logic [3:0]   state_code;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [47:0] last_frame;

  always #5 clk = ~clk;

  sd_cmd_path dut (
    .clk(clk), .rst(rst), .clk_en(clk_en), .req_valid(req_valid),
    .req_index(req_index), .req_arg(req_arg), .req_rsp(req_rsp),
    .req_ready(req_ready), .cmd_o(cmd_o), .cmd_oe(cmd_oe), .cmd_i(cmd_i),
    .done(done), .err_timeout(err_timeout), .err_crc(err_crc), .err_end(err_end),
    .rsp_payload(rsp_payload), .last_index(last_index), .state_code(state_code)
  );

  task automatic chk(input bit ok, input string tag, input logic [135:0] act, input logic [135:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Remainder of m * x^7 divided by x^7 + x^3 + 1.
  function automatic logic [6:0] ref_crc(input logic [39:0] m);
    logic [46:0] r;
    r = {m, 7'b0};
    for (int i = 46; i >= 7; i--) if (r[i]) r[i-:8] = r[i-:8] ^ 8'h89;
    return r[6:0];
  endfunction

  function automatic logic [3:0] exp_tx_code(input int b);
    if (b == 0) return 4'd2;
    if (b == 1) return 4'd3;
    if (b < 40) return 4'd4;
    if (b < 47) return 4'd5;
    return 4'd6;
  endfunction

  function automatic logic [3:0] exp_rx_code(input int j, input bit lng);
    int total;
    total = lng ? 136 : 48;
    if (j == 0) return 4'd7;
    if (j == 1) return 4'd9;
    if (j < 8) return 4'd10;
    if (j < total - 8) return 4'd11;
    if (j < total - 1) return 4'd12;
    return 4'd13;
  endfunction

  task automatic step(input logic ci, output bit e);
    logic [3:0] prev;
    e = ($urandom % 4) != 0;
    prev = state_code;
    @(negedge clk);
    clk_en = e;
    cmd_i = ci;
    @(posedge clk);
    #1;
    if (!e && prev != 4'd0) chk(state_code == prev, "R13 state held without enable", state_code, prev);
  endtask

  task automatic en_step(input logic ci);
    bit e;
    e = 0;
    while (!e) step(ci, e);
  endtask

  // mode: 0 clean reply, 1 corrupt CRC, 2 end bit low, 3 no reply
  task automatic run_cmd(input logic [5:0] idx, input logic [31:0] arg, input logic [1:0] rsp,
                         input bit first, input int delay, input int mode, input bit poke);
    logic [47:0]  fr, got;
    logic [135:0] rf;
    logic [31:0]  p32;
    logic [119:0] p120;
    logic [39:0]  body;
    logic [6:0]   c;
    logic [5:0]   prev_idx;
    bit           cok, oeok, lng;
    int           n, total;
    prev_idx = last_index;
    chk(req_ready && state_code == 4'd0, "R12 ready only when idle", state_code, 0);
    @(negedge clk);
    clk_en = 1'b0;
    req_valid = 1'b1; req_index = idx; req_arg = arg; req_rsp = rsp;
    @(posedge clk);
    #1;
    req_valid = 1'b0; req_index = $urandom; req_arg = $urandom;
    chk(!req_ready, "R12 ready low when busy", req_ready, 0);
    if (first) begin
      chk(state_code == 4'd1, "R2 init entered", state_code, 1);
      n = 0; cok = 1;
      while (state_code == 4'd1) begin
        if (!(cmd_o && cmd_oe)) cok = 0;
        en_step(1'b1);
        n++;
      end
      chk(n == 80, "R2 init length", n, 80);
      chk(cok, "R2 init drives high", 0, 1);
    end else begin
      chk(state_code == 4'd2, "R2 no repeated init", state_code, 2);
    end
    fr = {2'b01, idx, arg, ref_crc({2'b01, idx, arg}), 1'b1};
    got = '0; cok = 1; oeok = 1;
    for (int i = 0; i < 48; i++) begin
      got[47-i] = cmd_o;
      if (state_code != exp_tx_code(i)) cok = 0;
      if (!cmd_oe) oeok = 0;
      if (poke && i == 20) begin
        req_valid = 1'b1; req_index = ~idx; req_arg = ~arg; req_rsp = 2'b00;
      end
      en_step(1'b1);
      req_valid = 1'b0;
    end
    last_frame = got;
    chk(got == fr, "R3 command frame", got, fr);
    chk(cok, "R5 transmit state codes", 0, 1);
    chk(oeok, "R3 drive enable during frame", 0, 1);
    chk(!cmd_oe, "R3 drive released after end bit", cmd_oe, 0);
    if (rsp == 2'b00) begin
      chk(done && state_code == 4'd14, "R6 done and gap after no-reply command", {done, state_code}, {1'b1, 4'd14});
    end else begin
      chk(state_code == 4'd15, "R7 turnaround entered", state_code, 15);
      if (mode == 3) begin
        n = 0;
        while (state_code == 4'd15) begin en_step(1'b1); n++; end
        chk(n == 64, "R7 timeout window", n, 64);
        chk(err_timeout && done && state_code == 4'd14, "R7 timeout flag", {err_timeout, done, state_code}, {2'b11, 4'd14});
        chk(last_index == prev_idx, "R11 index kept on timeout", last_index, prev_idx);
      end else begin
        for (int d = 0; d < delay; d++) en_step(1'b1);
        chk(state_code == 4'd15, "R7 still waiting before start bit", state_code, 15);
        lng = rsp[1];
        total = lng ? 136 : 48;
        p32 = $urandom;
        p120 = {$urandom, $urandom, $urandom, $urandom};
        if (lng) begin
          rf = {2'b00, 6'h3F, p120, 7'($urandom), (mode == 2) ? 1'b0 : 1'b1};
        end else begin
          body = {2'b00, idx, p32};
          c = ref_crc(body);
          if (mode == 1) c = c ^ 7'h01;
          rf = {88'b0, body, c, (mode == 2) ? 1'b0 : 1'b1};
        end
        cok = 1;
        for (int j = 0; j < total; j++) begin
          en_step(rf[total-1-j]);
          if (state_code != exp_rx_code(j, lng)) cok = 0;
        end
        chk(cok, lng ? "R9 long reply state codes" : "R8 short reply state codes", 0, 1);
        chk(done && state_code == 4'd13, "R10 done on end of reply", {done, state_code}, {1'b1, 4'd13});
        if (lng) begin
          chk(rsp_payload == p120, "R9 long payload", rsp_payload, p120);
          chk(!err_crc, "R9 long trailing bits unchecked", err_crc, 0);
          chk(last_index == 6'h3F, "R11 index of long reply", last_index, 6'h3F);
        end else begin
          chk(rsp_payload == {88'b0, p32}, "R8 short payload", rsp_payload, p32);
          chk(err_crc == (mode == 1), "R8 CRC check", err_crc, mode == 1);
          chk(last_index == idx, "R11 index of short reply", last_index, idx);
        end
        chk(err_end == (mode == 2), "R10 end bit check", err_end, mode == 2);
        chk(!err_timeout, "R7 no timeout on reply", err_timeout, 0);
        cmd_i = 1'b1;
        en_step(1'b1);
        chk(state_code == 4'd14, "R10 gap after reply", state_code, 14);
      end
    end
    n = 0;
    while (state_code == 4'd14) begin en_step(1'b1); n++; end
    chk(n == 8, "R6 gap length", n, 8);
    chk(state_code == 4'd0 && req_ready, "R6 back to idle", state_code, 0);
    if (rsp == 2'b00) chk(last_index == prev_idx, "R11 index kept without reply", last_index, prev_idx);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7031));
    repeat (4) @(posedge clk);
    #1;
    chk(state_code == 4'd0 && req_ready && !cmd_oe && !done, "R1 reset state", {state_code, req_ready, cmd_oe, done}, {4'd0, 3'b100});
    chk(last_index == 6'd0 && !err_timeout && !err_crc && !err_end, "R1 reset flags", last_index, 0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    chk(state_code == 4'd0 && req_ready, "R1 idle after reset", state_code, 0);

    run_cmd(6'd0, 32'h0, 2'b00, 1'b1, 0, 0, 1'b0);
    chk(last_frame[7:1] == 7'h4A, "R4 known CRC index 0", last_frame[7:1], 7'h4A);
    run_cmd(6'd8, 32'h1AA, 2'b01, 1'b0, 0, 0, 1'b0);
    chk(last_frame[7:1] == 7'h43, "R4 known CRC index 8", last_frame[7:1], 7'h43);
    run_cmd(6'd17, 32'hDEAD_BEEF, 2'b01, 1'b0, 63, 0, 1'b1);
    run_cmd(6'd55, 32'h1234_5678, 2'b01, 1'b0, 0, 3, 1'b0);
    run_cmd(6'd13, 32'h0F0F_0F0F, 2'b01, 1'b0, 5, 1, 1'b0);
    run_cmd(6'd16, 32'h0000_0200, 2'b01, 1'b0, 2, 2, 1'b0);
    run_cmd(6'd2, 32'h0, 2'b10, 1'b0, 3, 0, 1'b1);
    run_cmd(6'd9, 32'hFFFF_0000, 2'b11, 1'b0, 10, 1, 1'b0);
    run_cmd(6'd12, 32'h0, 2'b01, 1'b0, 1, 0, 1'b0);
    run_cmd(6'd7, 32'h5555_AAAA, 2'b00, 1'b0, 0, 0, 1'b1);

    for (int k = 0; k < 25; k++) begin
      logic [1:0] rk;
      rk = 2'($urandom % 3);
      run_cmd(6'($urandom), $urandom, rk, 1'b0, int'($urandom % 64),
              (rk == 2'b00) ? 0 : int'($urandom % 4), 1'($urandom));
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule